// File: doc/BRIEF.md
# Fourth-Order CIC Decimator for a One-Bit Oversampled Stream

This block turns the one-bit stream of an oversampling modulator into signed multi-bit words at one sixteenth of the input rate. Each accepted bit is read as +1 or -1. It then passes through four running-sum stages that work at the input rate. Every sixteenth accepted sample goes on to four first-difference stages that work only at the reduced rate. The overall response is a fourth-order sinc. Its nulls fall on every multiple of the output rate, so noise near those frequencies does not fold into the band of interest. The block uses no multipliers and stores no coefficients.

All arithmetic is modular two's complement. The running sums are allowed to wrap freely. The differences remove the wrap again, provided the internal word holds the full gain of M^N = 2^16 plus sign. The result is normalised to unity DC gain by an arithmetic right shift. The output is a Q1.14 fraction, so a constant +1 input reads as 16384. Filtering after this stage, such as droop correction, is done by downstream logic.

Top module: `cic_decimator`

## Requirements
- R1: Exactly one `out_valid` pulse is produced for every 16 accepted inputs (cycles with `in_valid` high). It appears in the cycle after the clock edge that takes the sixteenth input.
- R2: `out_valid` is high for exactly one clock per output word.
- R3: Input bit 1 counts as +1 and bit 0 as -1. In steady state, a constant stream of ones gives `out_word` = 16384 and a constant stream of zeros gives -16384 (Q1.14, unity DC gain).
- R4: A cycle with `in_valid` low changes no state. Idle cycles inserted between inputs leave the output sequence unchanged and produce no `out_valid` in the following cycle.
- R5: The internal sums wrap around modulo 2^18 without any saturation. The steady-state output stays exact after more than a thousand inputs of the same value.
- R6: A stream that alternates 1,0,1,0 lies on a null of the response and gives `out_word` = 0 in steady state.
- R7: The pattern 1,0,0,0 repeated has mean -0.5 and gives `out_word` = -8192 in steady state.
- R8: Synchronous reset clears the phase counter, all sums, all difference delays and the outputs (`out_valid` = 0, `out_word` = 0). No `out_valid` occurs until 16 inputs have been accepted after reset.
- R9: `out_word` holds its value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_bit` for this cycle |
| in_bit | input | 1 | Modulator bit, 1 = +1, 0 = -1 |
| out_valid | output | 1 | One-cycle pulse marking a new output word |
| out_word | output | OUT_W (16) | Signed Q1.14 decimated sample |

## Verification
The output register loads at the same clock edge that takes the sixteenth input. Every input is therefore driven at a falling edge and the outputs are read one nanosecond after the next rising edge, so each pulse is tied to the input that caused it. The impulse response spans 61 input samples and the running sums add a few samples of latency, so value checks use only the last three words of a ten-block run, all of which lie well past that transient. Hold and idle behaviour is read in the same place during cycles with `in_valid` low.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Default configuration of the decimator.
    localparam int unsigned CIC_RATE_DEF   = 16;
    localparam int unsigned CIC_ORDER_DEF  = 4;
    localparam int unsigned CIC_OUT_W_DEF  = 16;

    // Per-cycle control produced by the phase counter.
    typedef struct packed {
        logic accept;   // an input sample is taken this cycle
        logic dump;     // this sample closes a block of RATE inputs
    } cic_tick_t;

endpackage

// File: rtl/cic_phase_counter.sv
module cic_phase_counter
    import cic_pkg::*;
#(
    parameter int unsigned RATE = CIC_RATE_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    output cic_tick_t tick
);
    localparam int unsigned CNT_W = (RATE > 1) ? $clog2(RATE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] phase;
    } phase_state_t;

    phase_state_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        tick.accept = in_valid;
        tick.dump   = in_valid && (st_q.phase == LAST);
        if (in_valid) begin
            if (st_q.phase == LAST) begin
                st_d.phase = '0;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cic_integrator_chain.sv
module cic_integrator_chain #(
    parameter int unsigned ORDER = 4,
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [WIDTH-1:0] sample,
    output logic [WIDTH-1:0] sum_last
);
    typedef struct packed {
        logic [ORDER-1:0][WIDTH-1:0] acc;
    } integ_state_t;

    integ_state_t st_q, st_d;

    // Feed of each stage: the mapped input for the first, the previous
    // stage's register for the rest (one register per stage, modular adds).
    logic [ORDER-1:0][WIDTH-1:0] feed;

    genvar g;
    generate
        for (g = 0; g < ORDER; g++) begin : g_feed
            if (g == 0) begin : g_head
                assign feed[g] = sample;
            end else begin : g_tail
                assign feed[g] = st_q.acc[g-1];
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (accept) begin
            for (int k = 0; k < ORDER; k++) begin
                st_d.acc[k] = st_q.acc[k] + feed[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_last = st_q.acc[ORDER-1];

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
    parameter int unsigned ORDER = 4,
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dump,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [ORDER-1:0][WIDTH-1:0] dly;
    } comb_state_t;

    comb_state_t st_q, st_d;

    // stage_in[k] enters difference stage k; stage_in[ORDER] is the result.
    logic [ORDER:0][WIDTH-1:0] stage_in;

    assign stage_in[0] = din;

    genvar g;
    generate
        for (g = 0; g < ORDER; g++) begin : g_diff
            assign stage_in[g+1] = stage_in[g] - st_q.dly[g];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (dump) begin
            for (int k = 0; k < ORDER; k++) begin
                st_d.dly[k] = stage_in[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = stage_in[ORDER];

endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
    import cic_pkg::*;
#(
    parameter int unsigned DEC_FACTOR = CIC_RATE_DEF,
    parameter int unsigned ORDER      = CIC_ORDER_DEF,
    parameter int unsigned OUT_W      = CIC_OUT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_word
);
    localparam int unsigned LOG2_RATE = $clog2(DEC_FACTOR);
    localparam int unsigned GROWTH    = ORDER * LOG2_RATE;
    // Full-scale sum is +/- 2^GROWTH; one extra bit keeps +2^GROWTH apart.
    localparam int unsigned REG_W     = GROWTH + 2;
    localparam int unsigned FRAC_BITS = OUT_W - 2;
    localparam int unsigned SHIFT     = GROWTH - FRAC_BITS;

    cic_tick_t        tick;
    logic [REG_W-1:0] mapped;
    logic [REG_W-1:0] integ_out;
    logic [REG_W-1:0] comb_out;

    // +1 for a one, -1 for a zero.
    assign mapped = in_bit ? {{(REG_W-1){1'b0}}, 1'b1} : {REG_W{1'b1}};

    cic_phase_counter #(
        .RATE (DEC_FACTOR)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .tick     (tick)
    );

    cic_integrator_chain #(
        .ORDER (ORDER),
        .WIDTH (REG_W)
    ) u_integ (
        .clk      (clk),
        .rst      (rst),
        .accept   (tick.accept),
        .sample   (mapped),
        .sum_last (integ_out)
    );

    cic_comb_chain #(
        .ORDER (ORDER),
        .WIDTH (REG_W)
    ) u_comb (
        .clk  (clk),
        .rst  (rst),
        .dump (tick.dump),
        .din  (integ_out),
        .dout (comb_out)
    );

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] word;
    } out_state_t;

    out_state_t       st_q, st_d;
    logic signed [REG_W-1:0] scaled;

    assign scaled = $signed(comb_out) >>> SHIFT;

    always_comb begin
        st_d       = st_q;
        st_d.valid = tick.dump;
        if (tick.dump) begin
            st_d.word = scaled[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;

endmodule

// File: rtl/cic_decimator_checker.sv
module cic_decimator_checker #(
    parameter int unsigned DEC_FACTOR = 16,
    parameter int unsigned OUT_W      = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_word
);
    localparam int unsigned SEEN_W = $clog2(DEC_FACTOR) + 2;

    // Inputs accepted since reset or since the last output pulse.
    logic [SEEN_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else begin
            seen_q <= (out_valid ? '0 : seen_q) + SEEN_W'(in_valid);
        end
    end

    // R1: a word follows exactly DEC_FACTOR accepted inputs.
    p_block_len_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seen_q == SEEN_W'(DEC_FACTOR)));

    // R2: single-cycle pulse.
    p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4: no pulse after an idle cycle.
    p_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8: reset leaves outputs cleared.
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && out_word == '0));

    // R9: word holds between pulses.
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_word));

endmodule

bind cic_decimator cic_decimator_checker #(
    .DEC_FACTOR (DEC_FACTOR),
    .OUT_W      (OUT_W)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/cic_decimator_test.sv
`timescale 1ns/1ps
module cic_decimator_test;
    localparam int OUT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_bit = 1'b0;
    logic             out_valid;
    logic [OUT_W-1:0] out_word;

    int checks = 0;
    int fails  = 0;
    int n_out  = 0;
    int last_out = 0;
    int doubles = 0;
    logic prev_valid = 1'b0;

    always #2.5 clk = ~clk;

    cic_decimator uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, observe 1 ns after the rising edge.
    task automatic tick_in(input bit v, input bit b);
        @(negedge clk);
        in_valid = v;
        in_bit   = b;
        @(posedge clk);
        #1;
        if (out_valid) begin
            n_out++;
            last_out = $signed(out_word);
            if (prev_valid) doubles++;
        end
        prev_valid = out_valid;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        n_out = 0;
        prev_valid = 1'b0;
    endtask

    function automatic bit pat(input int kind, input int i);
        case (kind)
            0: return 1'b1;
            1: return 1'b0;
            2: return (i % 2) == 0;
            default: return (i % 4) == 0;
        endcase
    endfunction

    // Runs BLOCKS blocks of 16 inputs; GAP inserts idle cycles between inputs.
    task automatic run_pattern(input int kind, input int blocks, input bit gap,
                               input int exp, input string req);
        int hits;
        hits = 0;
        do_reset();
        for (int i = 0; i < blocks * 16; i++) begin
            tick_in(1'b1, pat(kind, i));
            if (out_valid && n_out > blocks - 3) begin
                check($signed(out_word) == exp, req, $signed(out_word), exp);
                hits++;
            end
            if (gap) begin
                for (int j = 0; j < (i % 3); j++) begin
                    tick_in(1'b0, 1'b1);
                    // R4: idle cycle produces no pulse
                    if (out_valid) check(1'b0, "R4", 1, 0);
                end
            end
        end
        check(n_out == blocks, "R1", n_out, blocks);
        check(hits == 3, req, hits, 3);
    endtask

    task automatic t_first_block();
        int held;
        do_reset();
        // R8: cleared outputs after reset
        check(out_valid == 1'b0, "R8", out_valid, 0);
        check($signed(out_word) == 0, "R8", $signed(out_word), 0);
        for (int i = 0; i < 15; i++) tick_in(1'b1, 1'b1);
        check(n_out == 0, "R8", n_out, 0);
        tick_in(1'b1, 1'b1);
        check(out_valid == 1'b1, "R1", out_valid, 1);
        held = $signed(out_word);
        tick_in(1'b0, 1'b0);
        check(out_valid == 1'b0, "R2", out_valid, 0);
        for (int i = 0; i < 6; i++) tick_in(1'b0, 1'b0);
        // R9: word held while idle
        check($signed(out_word) == held, "R9", $signed(out_word), held);
        check(n_out == 1, "R4", n_out, 1);
    endtask

    task automatic t_mid_reset();
        for (int i = 0; i < 40; i++) tick_in(1'b1, 1'b0);
        do_reset();
        check(out_valid == 1'b0 && $signed(out_word) == 0, "R8", $signed(out_word), 0);
        for (int i = 0; i < 15; i++) tick_in(1'b1, 1'b1);
        check(n_out == 0, "R8", n_out, 0);
        tick_in(1'b1, 1'b1);
        check(out_valid == 1'b1, "R8", out_valid, 1);
    endtask

    initial begin
        #500000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_first_block();
        run_pattern(0, 10, 1'b0, 16384, "R3");
        run_pattern(1, 10, 1'b0, -16384, "R3");
        run_pattern(2, 10, 1'b0, 0, "R6");
        run_pattern(3, 10, 1'b0, -8192, "R7");
        run_pattern(0, 80, 1'b0, 16384, "R5");
        run_pattern(1, 80, 1'b0, -16384, "R5");
        run_pattern(0, 10, 1'b1, 16384, "R4");
        run_pattern(3, 10, 1'b1, -8192, "R4");
        t_mid_reset();
        // R2: no back-to-back pulses seen anywhere
        check(doubles == 0, "R2", doubles, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule